// File: doc/BRIEF.md
# Prescaled Match Timer

A 32-bit up-counting timer reached through a small register bus. A prescale counter divides the clock: each time it reaches the programmed prescale limit it wraps to zero, and the timer counter steps by one. One match register is compared against the value the timer counter is about to take. A match can do any mix of three things: set an interrupt flag, return the counter to zero, or stop the timer by clearing its enable bit.

With all three actions set and a match value of 1, a single write of the prescale register followed by an enable gives a one-shot delay of prescale+1 clocks. The flag drives a level interrupt and is cleared by writing a one to it. The mode register is stored and read back. Only mode 0, the internal-clock timer mode, lets the counters advance.

Top module: `match_timer`

## Requirements
- R1: After synchronous reset every register reads 0, `bus_rdata` is 0 and `irq_o` is low.
- R2: Register map, by byte address: 0x000 flag (bit 0), 0x004 control (bit 0 run enable, bit 1 hold-at-zero), 0x008 timer counter (32 bits, writable), 0x00C prescale limit (32 bits), 0x014 match actions (bit 0 flag, bit 1 return-to-zero, bit 2 stop), 0x018 match value (32 bits), 0x070 mode (2 bits). Each reads back what was written, and unused bits and addresses read 0.
- R3: While running, the timer counter advances once every prescale+1 clocks. A prescale of 0 advances it on every clock.
- R4: With the run enable at 0, neither the timer counter nor the prescale counter changes, and counting resumes from the held prescale count.
- R5: While hold-at-zero is 1, the timer counter and the prescale counter are forced to 0.
- R6: Without return-to-zero, the counter steps from 0xFFFFFFFF to 0.
- R7: When the counter steps to the match value and action bit 0 is set, the flag is set on that clock and `irq_o` follows the flag. With bit 0 clear, no flag is raised.
- R8: When the counter steps to the match value and action bit 1 is set, the counter becomes 0 instead. With match value 3 the sequence is 1, 2, 0, 1, ...
- R9: When the counter steps to the match value and action bit 2 is set, the run enable bit is cleared in the same clock.
- R10: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged.
- R11: If a flag-clear write and a flag-setting match occur in the same clock, the flag ends set.
- R12: A nonzero mode value stops the counters from advancing.
- R13: `bus_rdata` is registered: one clock after an address is presented, it shows that register's value as held just before that clock edge. The timer counter is read live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt, high while the match flag is set |

## Verification
The counter is driven with prescale limits 0 and 3, which separates a per-clock step from a divided step and shows the prescale count surviving a pause. Match actions are tried singly and together: flag only, return-to-zero only (a 1, 2, 0 cycle), flag with return-to-zero, and all three as a one-shot. Each combination shows which action fired and which did not. Further patterns cover a load near the top of the range to expose the wrap, a flag clear that lands on the same clock as a match, a nonzero mode, and back-to-back reads of a running counter to pin down the read latency.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned OFS_FLAG  = 'h000;
  localparam int unsigned OFS_CTRL  = 'h004;
  localparam int unsigned OFS_COUNT = 'h008;
  localparam int unsigned OFS_PRE   = 'h00C;
  localparam int unsigned OFS_ACT   = 'h014;
  localparam int unsigned OFS_MATCH = 'h018;
  localparam int unsigned OFS_MODE  = 'h070;

  // Match actions, bit positions are software visible
  typedef struct packed {
    logic stop;   // bit 2
    logic zero;   // bit 1
    logic flag;   // bit 0
  } act_t;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pc_q;

  // >= keeps a lowered limit from stranding the count above it
  assign tick = run && (pc_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      pc_q <= '0;
    end else if (run) begin
      pc_q <= tick ? '0 : pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] match_val,
  input  logic         zero_on_match,
  output logic [W-1:0] count,
  output logic         match_evt
);
  logic [W-1:0] count_q;
  logic [W-1:0] step;

  assign step      = count_q + 1'b1;
  assign match_evt = tick && !load && !hold && (step == match_val);
  assign count     = count_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (tick) begin
      count_q <= (match_evt && zero_on_match) ? '0 : step;
    end
  end
endmodule

// File: rtl/mt_regs.sv
module mt_regs
  import mt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count,
  input  logic              match_evt,
  output logic              run_en,
  output logic              hold,
  output logic [DATA_W-1:0] pre_lim,
  output act_t              act,
  output logic [DATA_W-1:0] match_val,
  output logic [MODE_W-1:0] mode,
  output logic              flag,
  output logic              count_load,
  output logic [DATA_W-1:0] rdata
);
  logic sel_flag, sel_ctrl, sel_count, sel_pre, sel_act, sel_match, sel_mode;

  assign sel_flag  = (addr == ADDR_W'(OFS_FLAG));
  assign sel_ctrl  = (addr == ADDR_W'(OFS_CTRL));
  assign sel_count = (addr == ADDR_W'(OFS_COUNT));
  assign sel_pre   = (addr == ADDR_W'(OFS_PRE));
  assign sel_act   = (addr == ADDR_W'(OFS_ACT));
  assign sel_match = (addr == ADDR_W'(OFS_MATCH));
  assign sel_mode  = (addr == ADDR_W'(OFS_MODE));

  assign count_load = we && sel_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en    <= 1'b0;
      hold      <= 1'b0;
      pre_lim   <= '0;
      act       <= '0;
      match_val <= '0;
      mode      <= '0;
    end else begin
      if (we && sel_ctrl) {hold, run_en} <= wdata[1:0];
      if (we && sel_pre)   pre_lim   <= wdata;
      if (we && sel_act)   act       <= act_t'(wdata[2:0]);
      if (we && sel_match) match_val <= wdata;
      if (we && sel_mode)  mode      <= wdata[MODE_W-1:0];
      // stop action overrides a same-cycle enable write
      if (match_evt && act.stop) run_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else begin
      if (we && sel_flag && wdata[0]) flag <= 1'b0;
      if (match_evt && act.flag)      flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      unique case (1'b1)
        sel_flag:  rdata[0]        <= flag;
        sel_ctrl:  rdata[1:0]      <= {hold, run_en};
        sel_count: rdata           <= count;
        sel_pre:   rdata           <= pre_lim;
        sel_act:   rdata[2:0]      <= act;
        sel_match: rdata           <= match_val;
        sel_mode:  rdata[MODE_W-1:0] <= mode;
        default:   rdata           <= '0;
      endcase
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic              ctrl_en, ctrl_hold, tick, match_evt, count_load, flag_q, run;
  logic [DATA_W-1:0] pre_lim, match_val, count_q;
  logic [MODE_W-1:0] mode_q;
  act_t              act_q;

  assign run   = ctrl_en && !ctrl_hold && (mode_q == '0);
  assign irq_o = flag_q;

  mt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .count(count_q), .match_evt(match_evt), .run_en(ctrl_en), .hold(ctrl_hold),
    .pre_lim(pre_lim), .act(act_q), .match_val(match_val), .mode(mode_q),
    .flag(flag_q), .count_load(count_load), .rdata(bus_rdata)
  );

  mt_prescaler #(.W(DATA_W)) u_pre (
    .clk(clk), .rst(rst), .hold(ctrl_hold), .run(run), .limit(pre_lim), .tick(tick)
  );

  mt_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .hold(ctrl_hold), .tick(tick), .load(count_load),
    .load_val(bus_wdata), .match_val(match_val), .zero_on_match(act_q.zero),
    .count(count_q), .match_evt(match_evt)
  );
endmodule

// File: rtl/mt_chk.sv
module mt_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MODE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_o,
  input logic              en,
  input logic              hold,
  input logic [MODE_W-1:0] mode,
  input logic [DATA_W-1:0] count,
  input logic              count_load,
  input logic              tick,
  input logic              match_evt,
  input logic [2:0]        act
);
  // R5
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (count == '0));
  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !count_load && !hold) |=> $stable(count));
  // R12
  mode_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode != '0) && !count_load && !hold) |=> $stable(count));
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !count_load && !hold && !act[1] && (count == '1)) |=> (count == '0));
  // R9
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (match_evt && act[2]) |=> !en);
  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (match_evt && act[0]) |=> irq_o);
  // R7
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(match_evt && act[0]));
endmodule

bind match_timer mt_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .en(ctrl_en), .hold(ctrl_hold),
  .mode(mode_q), .count(count_q), .count_load(count_load), .tick(tick),
  .match_evt(match_evt), .act(act_q)
);

// File: tb/sim_match_timer.sv
`timescale 1ns/1ps
module sim_match_timer;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [AW-1:0] A_FLAG = 8'h00, A_CTRL = 8'h04, A_CNT = 8'h08,
    A_PRE = 8'h0C, A_ACT = 8'h14, A_MATCH = 8'h18, A_MODE = 8'h70;

  always #5 clk = ~clk;

  match_timer #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 32'd0);
    rd(A_CNT, v);   chk("R1 count", v, 32'd0);
    rd(A_PRE, v);   chk("R1 pre", v, 32'd0);
    rd(A_ACT, v);   chk("R1 act", v, 32'd0);
    rd(A_MATCH, v); chk("R1 match", v, 32'd0);
    rd(A_MODE, v);  chk("R1 mode", v, 32'd0);
  endtask

  task automatic t_regmap();
    logic [DW-1:0] v;
    wr(A_ACT, 32'hFFFF_FFFD); rd(A_ACT, v); chk("R2 act bits", v, 32'd5);
    wr(A_MODE, 32'hFFFF_FFFE); rd(A_MODE, v); chk("R2 mode bits", v, 32'd2);
    wr(A_MATCH, 32'hA5A5_1234); rd(A_MATCH, v); chk("R2 match", v, 32'hA5A5_1234);
    rd(8'h10, v); chk("R2 unmapped", v, 32'd0);
    wr(A_MODE, 0); wr(A_ACT, 0); wr(A_MATCH, 0);
  endtask

  task automatic t_prescale();
    logic [DW-1:0] v;
    wr(A_PRE, 3);
    wr(A_CTRL, 2); wr(A_CTRL, 1);
    idle(10);
    wr(A_CTRL, 0);                       // 11 running clocks / 4
    rd(A_CNT, v); chk("R3 prescale 3", v, 32'd2);
    idle(5);
    rd(A_CNT, v); chk("R4 disabled hold", v, 32'd2);
    wr(A_CTRL, 1); wr(A_CTRL, 0);        // prescale count was left at 3
    rd(A_CNT, v); chk("R4 resume prescale", v, 32'd3);
    rd(A_PRE, v); chk("R2 pre", v, 32'd3);
    wr(A_CTRL, 3); idle(3);
    rd(A_CNT, v); chk("R5 hold zero", v, 32'd0);
    wr(A_CTRL, 0);
    wr(A_PRE, 0);
    wr(A_CTRL, 2); wr(A_CTRL, 1);
    idle(5);
    wr(A_CTRL, 0);
    rd(A_CNT, v); chk("R3 prescale 0", v, 32'd6);
  endtask

  task automatic t_read_live();
    logic [DW-1:0] a, b;
    wr(A_CTRL, 2); wr(A_CTRL, 1);
    rd(A_CNT, a); rd(A_CNT, b);
    wr(A_CTRL, 0);
    chk("R13 first read", a, 32'd0);
    chk("R13 second read", b, 32'd1);
  endtask

  task automatic t_match_flag();
    logic [DW-1:0] v;
    wr(A_MATCH, 5); wr(A_ACT, 1);
    wr(A_CTRL, 2); wr(A_CTRL, 1);
    idle(3); chk("R7 before match", {31'd0, irq_o}, 32'd0);
    idle(2); chk("R7 at match", {31'd0, irq_o}, 32'd1);
    wr(A_FLAG, 0); chk("R10 write zero", {31'd0, irq_o}, 32'd1);
    wr(A_CTRL, 0);
    rd(A_CNT, v); chk("R7 free run past match", v, 32'd7);
    rd(A_FLAG, v); chk("R2 flag read", v, 32'd1);
    wr(A_FLAG, 1); chk("R10 write one", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_zero_on_match();
    logic [DW-1:0] v;
    wr(A_MATCH, 3); wr(A_ACT, 2);
    wr(A_CTRL, 2); wr(A_CTRL, 1);
    idle(7);
    wr(A_CTRL, 0);                       // 8 steps: ...,1,2
    rd(A_CNT, v); chk("R8 cycle of three", v, 32'd2);
    chk("R7 no flag without bit0", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_oneshot();
    logic [DW-1:0] v;
    wr(A_PRE, 4); wr(A_MATCH, 1); wr(A_ACT, 7);
    wr(A_CTRL, 2); wr(A_CTRL, 1);
    idle(4); chk("R9 before delay end", {31'd0, irq_o}, 32'd0);
    idle(1); chk("R9 delay end irq", {31'd0, irq_o}, 32'd1);
    rd(A_CTRL, v); chk("R9 enable cleared", v, 32'd0);
    idle(10);
    rd(A_CNT, v); chk("R8 oneshot count", v, 32'd0);
    wr(A_FLAG, 1); wr(A_PRE, 0);
  endtask

  task automatic t_clear_race();
    wr(A_MATCH, 3); wr(A_ACT, 3);
    wr(A_CTRL, 2); wr(A_CTRL, 1);
    idle(2);
    wr(A_FLAG, 1);                       // same clock as the match
    chk("R11 set wins", {31'd0, irq_o}, 32'd1);
    wr(A_FLAG, 1);
    chk("R10 clear after race", {31'd0, irq_o}, 32'd0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_wrap();
    logic [DW-1:0] v;
    wr(A_CTRL, 2); wr(A_CTRL, 0);
    wr(A_ACT, 0); wr(A_MATCH, 0);
    wr(A_CNT, 32'hFFFF_FFFE);
    rd(A_CNT, v); chk("R2 count write", v, 32'hFFFF_FFFE);
    wr(A_CTRL, 1); idle(1); wr(A_CTRL, 0);
    rd(A_CNT, v); chk("R6 wrap", v, 32'd0);
    chk("R7 match ignored with act 0", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_mode();
    logic [DW-1:0] v;
    wr(A_CTRL, 2); wr(A_CTRL, 0);
    wr(A_MODE, 1);
    wr(A_CTRL, 1); idle(5); wr(A_CTRL, 0);
    rd(A_CNT, v); chk("R12 nonzero mode", v, 32'd0);
    rd(A_MODE, v); chk("R12 mode read", v, 32'd1);
    wr(A_MODE, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_regmap();
    t_prescale();
    t_read_live();
    t_match_flag();
    t_zero_on_match();
    t_oneshot();
    t_clear_race();
    t_wrap();
    t_mode();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule